// File: doc/BRIEF.md
# Audio Transmit Word Buffer with Underrun Replay

This block buffers outgoing audio words between a processor and a serial transmit shifter. The processor pushes words one at a time through a data-register write strobe. At the end of every transmitted word the shifter pulses a load strobe and takes the word presented on the load-data output.

Occupancy is tracked with a read pointer, a write pointer and a flag that records whether the most recent single-sided access was a write or a load. Equal pointers therefore mean full or empty depending on that flag. A programmable level drives an almost-empty warning, and this warning becomes the transmit request toward the interrupt and DMA logic.

When the shifter asks for a word while the buffer is empty, the previously sent word is handed out again and a sticky underrun flag is raised. The underrun blocks every transmit request until the processor clears it. A separate decoder enables the serial data driver only in the slots that the slot mask selects. Slots beyond the configured frame length are never driven.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset `empty`=1, `almost_empty`=1, `full`=0 and `underrun`=0.
- R2: Words leave on `ld_data` in the order they were written. With equal pointers, `full` is 1 if the last single-sided access was a write and `empty` is 1 if it was a load. Sixteen writes from empty give `full`=1, and sixteen loads after that give `empty`=1.
- R3: `almost_empty` is 1 when the stored word count is less than or equal to `level`, and 0 when the count is greater. A full buffer counts as 16 words.
- R4: A write while `full`=1 with no load in the same cycle is dropped. It changes neither pointer, and the dropped word never appears on `ld_data`.
- R5: A write and a load in the same cycle advance both pointers and leave the access flag unchanged. When full, the write is accepted because the load frees a place.
- R6: A load while `empty`=1 is an underrun. `ld_data` then shows the last word previously sent, the buffer stays empty, and `underrun` is 1 from the next cycle.
- R7: `irq_req` = `almost_empty` & !`underrun` & `irq_en`, and `dma_req` = `almost_empty` & !`underrun` & `dma_en`. No request is raised while `underrun` is 1, even when enabled.
- R8: `underrun` holds until a cycle with `uf_clr`=1 clears it. If an underrun and `uf_clr` occur in the same cycle, the flag ends up set.
- R9: `sd_oe` is 1 when bit `slot_idx` of `slot_mask` is 1 and `slot_idx` <= `slot_cnt`, where `slot_cnt` holds slots-per-frame minus one. Mask bits for slots above `slot_cnt` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe for the data register |
| wr_data | input | 16 | Word to store |
| ld_req | input | 1 | Shifter load strobe at end of word |
| ld_data | output | 16 | Word handed to the shifter |
| level | input | 4 | Almost-empty warning level |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| almost_empty | output | 1 | Count at or below `level` |
| underrun | output | 1 | Sticky underrun flag |
| uf_clr | input | 1 | Clear strobe for `underrun` |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| irq_req | output | 1 | Transmit interrupt request |
| dma_req | output | 1 | Transmit DMA request |
| slot_idx | input | 2 | Current slot number in the frame |
| slot_cnt | input | 2 | Slots per frame minus one |
| slot_mask | input | 4 | Per-slot drive enable |
| sd_oe | output | 1 | Serial data output enable |

## Verification
The buffer is exercised with a fill to the top followed by a full drain, a write against a full buffer, paired write-and-load cycles at both a low and a full occupancy, and loads against an empty buffer. Together these separate the two meanings of equal pointers, and show whether a dropped or replayed word leaks into the output order. The warning level is probed on both sides of the threshold, so that an off-by-one in the count comparison shows up. The slot decoder is walked through a vector set that puts mask bits both inside and outside the configured frame length.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;
endpackage

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ld_req,
    input  logic             uf_clr,
    input  logic [PTR_W-1:0] level,
    output logic             wr_fire,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             full,
    output logic             empty,
    output logic             almost_empty,
    output logic             underrun
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        acc_e             last;
        logic             uf;
    } st_t;

    st_t st_q, st_d;
    logic do_rd, do_wr, slip;
    logic [PTR_W:0] fill;

    always_comb begin
        st_d  = st_q;
        empty = (st_q.rp == st_q.wp) && (st_q.last == ACC_LOAD);
        full  = (st_q.rp == st_q.wp) && (st_q.last == ACC_WRITE);
        do_rd = ld_req && !empty;
        slip  = ld_req && empty;
        do_wr = wr_en && (!full || do_rd);
        st_d.wp = st_q.wp + PTR_W'(do_wr);
        st_d.rp = st_q.rp + PTR_W'(do_rd);
        if (do_wr && !do_rd)
            st_d.last = ACC_WRITE;
        else if (do_rd && !do_wr)
            st_d.last = ACC_LOAD;
        if (slip)
            st_d.uf = 1'b1;
        else if (uf_clr)
            st_d.uf = 1'b0;
        fill = full ? (PTR_W+1)'(DEPTH) : {1'b0, st_q.wp - st_q.rp};
        almost_empty = fill <= {1'b0, level};
        // on a slip the pointer steps back one place to re-read the last word
        rd_addr  = empty ? st_q.rp - PTR_W'(1) : st_q.rp;
        wr_addr  = st_q.wp;
        wr_fire  = do_wr;
        underrun = st_q.uf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp   <= '0;
            st_q.rp   <= '0;
            st_q.last <= ACC_LOAD;
            st_q.uf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we)
            mem_d[waddr] = wdata;
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/afifo_slot_gate.sv
module afifo_slot_gate #(
    parameter int SLOTS = 4,
    localparam int SIDX_W = $clog2(SLOTS)
) (
    input  logic [SIDX_W-1:0] slot_idx,
    input  logic [SIDX_W-1:0] slot_cnt,
    input  logic [SLOTS-1:0]  slot_mask,
    output logic              sd_oe
);
    logic [SLOTS-1:0] live;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign live[g] = slot_mask[g] && (SIDX_W'(g) <= slot_cnt);
    end

    always_comb sd_oe = live[slot_idx];
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int SLOTS  = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int SIDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_req,
    output logic [DATA_W-1:0] ld_data,
    input  logic [PTR_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              almost_empty,
    output logic              underrun,
    input  logic              uf_clr,
    input  logic              irq_en,
    input  logic              dma_en,
    output logic              irq_req,
    output logic              dma_req,
    input  logic [SIDX_W-1:0] slot_idx,
    input  logic [SIDX_W-1:0] slot_cnt,
    input  logic [SLOTS-1:0]  slot_mask,
    output logic              sd_oe
);
    logic             wr_fire;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic             tx_want;

    afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ld_req(ld_req),
        .uf_clr(uf_clr), .level(level), .wr_fire(wr_fire),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .full(full), .empty(empty),
        .almost_empty(almost_empty), .underrun(underrun)
    );

    afifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_addr),
        .wdata(wr_data), .raddr(rd_addr), .rdata(ld_data)
    );

    afifo_slot_gate #(.SLOTS(SLOTS)) u_gate (
        .slot_idx(slot_idx), .slot_cnt(slot_cnt), .slot_mask(slot_mask),
        .sd_oe(sd_oe)
    );

    always_comb begin
        tx_want = almost_empty && !underrun;
        irq_req = tx_want && irq_en;
        dma_req = tx_want && dma_en;
    end
endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int SIDX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              ld_req,
    input logic              uf_clr,
    input logic              full,
    input logic              empty,
    input logic              almost_empty,
    input logic              underrun,
    input logic              irq_req,
    input logic              dma_req,
    input logic [SIDX_W-1:0] slot_idx,
    input logic [SIDX_W-1:0] slot_cnt,
    input logic              sd_oe
);
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R2
    AST_EMPTY_WARNS: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !ld_req |=> full); // R4
    AST_PAIR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && ld_req |=> full); // R5
    AST_SLIP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        empty && ld_req |=> underrun); // R6
    AST_SLIP_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty && ld_req && !wr_en |=> empty); // R6
    AST_NO_REQ_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !irq_req && !dma_req); // R7
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !uf_clr |=> underrun); // R8
    AST_OE_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx > slot_cnt |-> !sd_oe); // R9
endmodule

bind audio_tx_fifo afifo_chk #(.SIDX_W(SIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ld_req(ld_req),
    .uf_clr(uf_clr), .full(full), .empty(empty),
    .almost_empty(almost_empty), .underrun(underrun), .irq_req(irq_req),
    .dma_req(dma_req), .slot_idx(slot_idx), .slot_cnt(slot_cnt),
    .sd_oe(sd_oe)
);

// File: tb/audio_tx_fifo_test.sv
module audio_tx_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ld_req = 1'b0;
    logic [15:0] ld_data;
    logic [3:0]  level = 4'd3;
    logic        full, empty, almost_empty, underrun;
    logic        uf_clr = 1'b0;
    logic        irq_en = 1'b1;
    logic        dma_en = 1'b1;
    logic        irq_req, dma_req;
    logic [1:0]  slot_idx = '0;
    logic [1:0]  slot_cnt = '0;
    logic [3:0]  slot_mask = '0;
    logic        sd_oe;

    int total = 0;
    int bad = 0;
    logic [15:0] got;

    always #2 clk = ~clk;

    audio_tx_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ld_req(ld_req), .ld_data(ld_data), .level(level), .full(full),
        .empty(empty), .almost_empty(almost_empty), .underrun(underrun),
        .uf_clr(uf_clr), .irq_en(irq_en), .dma_en(dma_en),
        .irq_req(irq_req), .dma_req(dma_req), .slot_idx(slot_idx),
        .slot_cnt(slot_cnt), .slot_mask(slot_mask), .sd_oe(sd_oe)
    );

    // {slot_idx, slot_cnt, slot_mask, expected sd_oe}
    localparam logic [8:0] SLOT_VEC [8] = '{
        {2'd0, 2'd3, 4'b0001, 1'b1},
        {2'd1, 2'd3, 4'b0001, 1'b0},
        {2'd3, 2'd3, 4'b1000, 1'b1},
        {2'd2, 2'd1, 4'b0100, 1'b0},
        {2'd3, 2'd1, 4'b1111, 1'b0},
        {2'd1, 2'd1, 4'b0010, 1'b1},
        {2'd0, 2'd0, 4'b1110, 1'b0},
        {2'd2, 2'd2, 4'b0100, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns ld_data seen before the rising edge
    task automatic cyc(input logic w, input logic [15:0] d, input logic l, input logic c,
                       output logic [15:0] seen);
        wr_en = w; wr_data = d; ld_req = l; uf_clr = c;
        #1 seen = ld_data;
        @(negedge clk);
        wr_en = 1'b0; ld_req = 1'b0; uf_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 empty", empty, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 full", full, 0);
        chk("R1 underrun", underrun, 0);
        chk("R7 irq at reset", irq_req, 1);

        // slot gating vectors
        foreach (SLOT_VEC[i]) begin
            {slot_idx, slot_cnt, slot_mask} = SLOT_VEC[i][8:1];
            #1 chk($sformatf("R9 vec%0d", i), sd_oe, SLOT_VEC[i][0]);
        end
        @(negedge clk);

        // fill with level 3
        for (int i = 0; i < 16; i++) begin
            cyc(1, 16'h1000 + 16'(i), 0, 0, got);
            if (i == 2) chk("R3 count3 at level", almost_empty, 1);
            if (i == 3) chk("R3 count4 above level", almost_empty, 0);
            if (i == 3) chk("R7 no irq above level", irq_req, 0);
        end
        chk("R2 full after 16", full, 1);
        chk("R2 not empty when full", empty, 0);
        cyc(1, 16'hDEAD, 0, 0, got);
        chk("R4 still full", full, 1);
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 1, 0, got);
            chk($sformatf("R2 R4 order %0d", i), got, 16'h1000 + 16'(i));
            if (i == 12) chk("R3 count3 after drain", almost_empty, 1);
        end
        chk("R2 empty after drain", empty, 1);
        chk("R2 not full after drain", full, 0);

        // underrun replay
        cyc(0, 0, 1, 0, got);
        chk("R6 replay word", got, 16'h100F);
        chk("R6 underrun set", underrun, 1);
        chk("R6 stays empty", empty, 1);
        chk("R7 irq blocked", irq_req, 0);
        chk("R7 dma blocked", dma_req, 0);
        cyc(0, 0, 1, 0, got);
        chk("R6 replay again", got, 16'h100F);
        repeat (3) cyc(0, 0, 0, 0, got);
        chk("R8 sticky", underrun, 1);
        cyc(0, 0, 0, 1, got);
        chk("R8 cleared", underrun, 0);
        chk("R7 irq back", irq_req, 1);
        chk("R7 dma back", dma_req, 1);
        cyc(0, 0, 1, 1, got);
        chk("R8 set wins over clear", underrun, 1);
        cyc(0, 0, 0, 1, got);

        // simultaneous write and load, low occupancy
        cyc(1, 16'hA001, 0, 0, got);
        cyc(1, 16'hA002, 1, 0, got);
        chk("R5 pair low data", got, 16'hA001);
        chk("R5 pair low not empty", empty, 0);
        chk("R5 pair low not full", full, 0);
        cyc(0, 0, 1, 0, got);
        chk("R5 second word", got, 16'hA002);
        chk("R5 empty after", empty, 1);

        // simultaneous at full
        for (int i = 0; i < 16; i++) cyc(1, 16'hB000 + 16'(i), 0, 0, got);
        cyc(1, 16'hC000, 1, 0, got);
        chk("R5 pair full data", got, 16'hB000);
        chk("R5 pair keeps full", full, 1);
        for (int i = 1; i < 16; i++) begin
            cyc(0, 0, 1, 0, got);
            chk($sformatf("R5 drain %0d", i), got, 16'hB000 + 16'(i));
        end
        cyc(0, 0, 1, 0, got);
        chk("R5 accepted word", got, 16'hC000);
        chk("R2 empty end", empty, 1);

        // enables
        irq_en = 1'b0;
        #1 chk("R7 irq disabled", irq_req, 0);
        chk("R7 dma enabled", dma_req, 1);
        dma_en = 1'b0;
        #1 chk("R7 dma disabled", dma_req, 0);

        @(negedge clk);
        finish_run();
    end
endmodule